// File: doc/BRIEF.md
# Triggered Multi-Channel Waveform Capture Buffer

This block keeps several processed signal streams in per-channel circular memories so that a host can examine one synchronized snapshot of all channels. A selector picks the data set routed to the memories: raw samples, amplitudes or phases. While armed, the memories overwrite themselves continuously. A trigger, either an internal register strobe or a synchronized edge on an external pin, starts a post-trigger count. After a fixed number of accepted samples, every channel freezes at the same point.

The frozen snapshot is then drained through an output stream. The stream runs channel by channel, oldest sample first within each channel. The final handshake re-arms capture. Upstream filters set the sample rate. A larger averaging length upstream therefore means the host waits longer for a record to complete.

The sample input uses valid/ready. A sample transfers on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low only while a frozen record waits to be read. A source that cannot stall must discard samples in that window. The read side also uses valid/ready. `out_valid` doubles as the record-ready flag. A word is consumed when `out_valid` and `out_ready` are both high. While `out_ready` is low, the presented word holds steady.

Top module: `wave_capture`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1, so the block is armed.
- R2: `mode` selects the stored data set: 0 stores `raw_data`, 1 stores `amp_data`, 2 stores `phs_data`, and 3 behaves as 0.
- R3: Every accepted sample writes all channels at once. Channel k takes bits [k*DW +: DW] of the selected input.
- R4: With `trig_ext_sel` = 0 only `trig_strobe` triggers. With `trig_ext_sel` = 1 only a rising edge on `trig_ext` triggers. The unselected source has no effect.
- R5: `trig_ext` passes through a two-flop synchronizer and then an edge detector. A high pulse of any length gives exactly one trigger, and a level that stays high gives no further trigger after re-arming.
- R6: After a trigger, the record freezes as soon as exactly DEPTH (default 1024) further samples have been accepted. At that edge `out_valid` rises and `in_ready` falls.
- R7: A trigger that arrives while the block is filling or holding a record is ignored. It neither restarts the count nor starts a new capture after re-arming.
- R8: Samples offered while `in_ready` is low are not stored, and the held record is unchanged.
- R9: Readout covers channel 0 first, then ascending channels. Each channel gives DEPTH words from oldest to newest, which are the DEPTH samples accepted after the trigger. `out_chan` names the channel, and `out_last` is 1 only on the final word of the final channel.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_chan` and `out_valid` hold their values.
- R11: The handshake on the word with `out_last` = 1 clears `out_valid` and raises `in_ready` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Data-set selector (raw, amplitude, phase) |
| trig_ext_sel | input | 1 | 1 selects the external trigger pin, 0 selects the strobe |
| trig_strobe | input | 1 | Internal trigger strobe, one cycle high |
| trig_ext | input | 1 | Asynchronous external trigger |
| in_valid | input | 1 | Sample valid for all streams |
| in_ready | output | 1 | Block accepts samples (armed or filling) |
| raw_data | input | NCH*DW | Raw samples, one lane per channel |
| amp_data | input | NCH*DW | Amplitude samples, one lane per channel |
| phs_data | input | NCH*DW | Phase samples, one lane per channel |
| out_valid | output | 1 | Record ready and current read word valid |
| out_ready | input | 1 | Host accepts the current read word |
| out_data | output | DW | Read word |
| out_chan | output | max(1,clog2(NCH)) | Channel of the read word |
| out_last | output | 1 | Final word of the final channel |

## Verification
The assertions assume that the host keeps `out_ready` at a defined level in every cycle. They also assume that `trig_ext`, although asynchronous in the field, settles between clock edges. The bench drives every input on the falling clock edge, so each input holds a clean value for a full period before the sampling edge. Triggers are issued while `in_valid` is low, so pre-trigger and post-trigger samples are never ambiguous. The bench also lets enough idle cycles pass after an external pulse for the synchronizer to deliver the edge before the samples begin.

// File: rtl/wcap_pkg.sv
package wcap_pkg;
  typedef enum logic [1:0] {
    ST_ARMED = 2'd0,
    ST_FILL  = 2'd1,
    ST_HOLD  = 2'd2
  } cap_state_t;

  localparam logic [1:0] SEL_RAW = 2'd0;
  localparam logic [1:0] SEL_AMP = 2'd1;
  localparam logic [1:0] SEL_PHS = 2'd2;
endpackage

// File: rtl/wcap_trig.sv
module wcap_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_sel,
  input  logic strobe,
  input  logic ext_in,
  output logic trig_evt
);
  logic meta_q, sync_q, prev_q;
  logic ext_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= ext_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign ext_rise = sync_q & ~prev_q;
  assign trig_evt = ext_sel ? ext_rise : strobe;

  // R5
  ext_edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise);
endmodule

// File: rtl/wcap_ctrl.sv
module wcap_ctrl
  import wcap_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int NCH   = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_evt,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  input  logic          out_ready,
  output logic          out_valid,
  output logic          out_last,
  output logic [AW-1:0] rd_addr,
  output logic [CW-1:0] rd_ch
);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] LAST_CH  = CW'(NCH - 1);

  cap_state_t    state;
  logic [AW-1:0] wr_ptr, fill_cnt, rd_off;

  assign in_ready  = (state != ST_HOLD);
  assign wr_en     = in_valid && in_ready;
  assign wr_addr   = wr_ptr;
  assign out_valid = (state == ST_HOLD);
  assign out_last  = (rd_ch == LAST_CH) && (rd_off == LAST_IDX);
  assign rd_addr   = wr_ptr + rd_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_ARMED;
      wr_ptr   <= '0;
      fill_cnt <= '0;
      rd_off   <= '0;
      rd_ch    <= '0;
    end else begin
      unique case (state)
        ST_ARMED: begin
          if (wr_en) wr_ptr <= wr_ptr + 1'b1;
          if (trig_evt) begin
            state    <= ST_FILL;
            fill_cnt <= '0;
          end
        end
        ST_FILL: begin
          if (wr_en) begin
            wr_ptr <= wr_ptr + 1'b1;
            if (fill_cnt == LAST_IDX) begin
              state  <= ST_HOLD;
              rd_off <= '0;
              rd_ch  <= '0;
            end else begin
              fill_cnt <= fill_cnt + 1'b1;
            end
          end
        end
        ST_HOLD: begin
          if (out_ready) begin
            if (rd_off == LAST_IDX) begin
              rd_off <= '0;
              if (rd_ch == LAST_CH) state <= ST_ARMED;
              else rd_ch <= rd_ch + 1'b1;
            end else begin
              rd_off <= rd_off + 1'b1;
            end
          end
        end
        default: state <= ST_ARMED;
      endcase
    end
  end

  // R6
  armed_no_direct_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARMED) |=> (state != ST_HOLD));

  // R7
  fill_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FILL && wr_en && fill_cnt != LAST_IDX)
      |=> (state == ST_FILL && fill_cnt == $past(fill_cnt) + 1'b1));

  // R8
  hold_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_HOLD) |=> $stable(wr_ptr));

  // R11
  last_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));
endmodule

// File: rtl/wcap_ram.sv
module wcap_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 1024,
  parameter int NCH   = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [NCH*DW-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  input  logic [CW-1:0]     rd_ch,
  output logic [DW-1:0]     rd_data
);
  logic [DW-1:0] lane_q [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    logic [DW-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data[g*DW +: DW];
    end
    assign lane_q[g] = mem[rd_addr];
  end

  always_comb begin
    rd_data = lane_q[0];
    for (int c = 1; c < NCH; c++) begin
      if (rd_ch == CW'(c)) rd_data = lane_q[c];
    end
  end
endmodule

// File: rtl/wave_capture.sv
module wave_capture
  import wcap_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 1024,
  parameter int NCH   = 2,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              trig_ext_sel,
  input  logic              trig_strobe,
  input  logic              trig_ext,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NCH*DW-1:0] raw_data,
  input  logic [NCH*DW-1:0] amp_data,
  input  logic [NCH*DW-1:0] phs_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic [CW-1:0]     out_chan,
  output logic              out_last
);
  logic              trig_evt, wr_en;
  logic [AW-1:0]     wr_addr, rd_addr;
  logic [NCH*DW-1:0] sel_data;

  always_comb begin
    unique case (mode)
      SEL_AMP: sel_data = amp_data;
      SEL_PHS: sel_data = phs_data;
      default: sel_data = raw_data;
    endcase
  end

  wcap_trig u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_sel  (trig_ext_sel),
    .strobe   (trig_strobe),
    .ext_in   (trig_ext),
    .trig_evt (trig_evt)
  );

  wcap_ctrl #(.DEPTH(DEPTH), .NCH(NCH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_evt  (trig_evt),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .rd_addr   (rd_addr),
    .rd_ch     (out_chan)
  );

  wcap_ram #(.DW(DW), .DEPTH(DEPTH), .NCH(NCH)) u_ram (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (sel_data),
    .rd_addr (rd_addr),
    .rd_ch   (out_chan),
    .rd_data (out_data)
  );

  // R10
  out_hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));
endmodule

// File: tb/tb_wave_capture.sv
module tb_wave_capture;
  localparam int DW    = 16;
  localparam int DEPTH = 1024;
  localparam int NCH   = 2;
  localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode = 2'd0;
  logic trig_ext_sel = 1'b0, trig_strobe = 1'b0, trig_ext = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [NCH*DW-1:0] raw_data = '0, amp_data = '0, phs_data = '0;
  logic out_valid, out_ready = 1'b0, out_last;
  logic [DW-1:0] out_data;
  logic [CW-1:0] out_chan;

  int nchk = 0, nfail = 0, seq = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  wave_capture #(.DW(DW), .DEPTH(DEPTH), .NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .trig_ext_sel(trig_ext_sel),
    .trig_strobe(trig_strobe), .trig_ext(trig_ext), .in_valid(in_valid),
    .in_ready(in_ready), .raw_data(raw_data), .amp_data(amp_data),
    .phs_data(phs_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_chan(out_chan), .out_last(out_last)
  );

  // rows: {mode[1:0], external trigger, back-pressure}
  localparam logic [3:0] ROWS [4] = '{4'b0000, 4'b0110, 4'b1001, 4'b1111};

  function automatic logic [DW-1:0] pat(int sid, int ch, int s);
    return DW'(((sid % 4) << 14) | ((ch % 4) << 12) | (s % 4096));
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic feed(int n);
    repeat (n) begin
      @(negedge clk);
      in_valid = 1'b1;
      for (int c = 0; c < NCH; c++) begin
        raw_data[c*DW +: DW] = pat(1, c, seq);
        amp_data[c*DW +: DW] = pat(2, c, seq);
        phs_data[c*DW +: DW] = pat(3, c, seq);
      end
      seq++;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic fire_int();
    trig_strobe = 1'b1;
    @(negedge clk);
    trig_strobe = 1'b0;
  endtask

  task automatic fire_ext();
    trig_ext = 1'b1;
    @(negedge clk);
    trig_ext = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic read_record(int base, int sid, bit bp, string req);
    int k = 0, bad = 0, fa = 0, fe = 0;
    bit stall = 0;
    while (k < NCH * DEPTH) begin
      @(negedge clk);
      begin
        int ch = k / DEPTH;
        logic [DW-1:0] e = pat(sid, ch, base + (k % DEPTH));
        bit el = (k == NCH * DEPTH - 1);
        if (!(out_valid && out_data == e && int'(out_chan) == ch && out_last == el)) begin
          if (bad == 0) begin fa = int'(out_data); fe = int'(e); end
          bad++;
        end
      end
      if (bp && (k % 5 == 2) && !stall) begin
        out_ready = 1'b0;
        stall = 1;
      end else begin
        out_ready = 1'b1;
        stall = 0;
        k++;
      end
    end
    @(negedge clk);
    out_ready = 1'b0;
    chk(bad == 0, req, fa, fe);
    // R11: final handshake re-arms
    chk(!out_valid && in_ready, "R11 rearm after last word", {out_valid, in_ready}, 1);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!out_valid && in_ready, "R1 reset state", {out_valid, in_ready}, 1);

    // table-driven captures: R2, R3, R6, R9, R10
    foreach (ROWS[r]) begin
      logic [1:0] m = ROWS[r][3:2];
      bit ext = ROWS[r][1];
      bit bp = ROWS[r][0];
      int sid = (m == 2'd1) ? 2 : (m == 2'd2) ? 3 : 1;
      mode = m;
      trig_ext_sel = ext;
      feed(5);
      if (ext) fire_ext(); else fire_int();
      base = seq;
      feed(DEPTH - 1);
      chk(!out_valid && in_ready, "R6 not frozen one sample early", out_valid, 0);
      feed(1);
      chk(out_valid && !in_ready, "R6 frozen after DEPTH samples", {out_valid, in_ready}, 2);
      read_record(base, sid, bp, "R2/R3/R9/R10 record contents");
    end

    // R7: trigger during fill ignored
    mode = 2'd0;
    trig_ext_sel = 1'b0;
    fire_int();
    base = seq;
    feed(100);
    fire_int();
    feed(DEPTH - 101);
    chk(!out_valid, "R7 fill trigger did not restart", out_valid, 0);
    feed(1);
    chk(out_valid, "R7 froze on original count", out_valid, 1);
    // R8: samples and trigger during hold
    fire_int();
    feed(10);
    chk(!in_ready, "R8 in_ready low in hold", in_ready, 0);
    read_record(base, 1, 0, "R8 record unchanged by held samples");
    feed(DEPTH + 5);
    chk(!out_valid, "R7 hold trigger not remembered", out_valid, 0);

    // R4: unselected sources ignored
    trig_ext_sel = 1'b0;
    fire_ext();
    feed(DEPTH + 5);
    chk(!out_valid, "R4 external ignored when strobe selected", out_valid, 0);
    trig_ext_sel = 1'b1;
    repeat (4) @(negedge clk);
    fire_int();
    feed(DEPTH + 5);
    chk(!out_valid, "R4 strobe ignored when external selected", out_valid, 0);

    // R5: held-high external level triggers once
    trig_ext = 1'b1;
    repeat (4) @(negedge clk);
    base = seq;
    feed(DEPTH);
    chk(out_valid, "R5 long pulse triggered", out_valid, 1);
    read_record(base, 1, 1, "R5 record from long pulse");
    feed(DEPTH + 5);
    chk(!out_valid, "R5 steady level gives no second trigger", out_valid, 0);
    trig_ext = 1'b0;
    repeat (4) @(negedge clk);

    finished = 1;
    summary();
    $finish;
  end
endmodule